// File: doc/BRIEF.md
# Backplane Bus Ownership Arbiter

This block sits in the first slot of a backplane chassis and decides which plug-in card may drive a shared parallel bus. Cards request ownership on one of several active-low request lines, one line per priority level. The arbiter watches the active-low busy line, and while the bus is free it answers the most important pending level on that level's active-low grant line. The winning card takes the busy line and then the grant is withdrawn. Cards further down the chain pass the grant on, and that logic lives on the cards, not here.

All backplane inputs are asynchronous to the local clock and are retimed before any decision uses them. While a card owns the bus, a request at a more important level makes the arbiter raise an active-low clear line toward the owner. The clear line falls away once the owner frees the bus.

Top module: `bkp_arbiter`

## Requirements
- R1: While `sys_rst_n` is sampled low at a rising edge, all `grant_n` bits and `clr_n` are high (inactive) after that edge, and the arbiter is idle.
- R2: At most one `grant_n` bit is low at any time. A low bit i means level i is granted.
- R3: No new grant is issued while the retimed `busy_n` is low. Requests made during that time have no effect on `grant_n` until the bus is freed.
- R4: When the bus is free and several levels request, the highest-numbered level wins: level 3 is the most important and level 0 the least.
- R5: A grant stays low until the retimed `busy_n` is seen low. It goes high at the rising edge that follows, which is the third rising edge after `busy_n` falls at the pin.
- R6: While the granted card owns the bus, a request at a level above the owner's level drives `clr_n` low. `clr_n` stays low until the bus is freed.
- R7: `clr_n` returns high at the rising edge after the retimed `busy_n` is seen high. The arbiter then becomes idle and can grant again.
- R8: Every backplane input passes through a two-flop synchronizer. A request reaching an idle arbiter on a free bus drives its `grant_n` bit low at the third rising edge after the pin changes, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local arbiter clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| req_n | input | 4 | Active-low bus requests, bit i is level i |
| busy_n | input | 1 | Active-low bus-busy line from the current owner |
| grant_n | output | 4 | Active-low grant outputs, bit i is level i |
| clr_n | output | 1 | Active-low request to the owner to release the bus |

## Verification
A wrong state register shows up at the pins within a few clocks. A stuck grant state leaves a `grant_n` bit low after `busy_n` has fallen, and this is visible three edges later. A lost owner level makes `clr_n` fall for a request that is less important than the owner, or fail to fall for one that is more important. A wrong number of synchronizer stages moves every grant and release by whole cycles, so the bench compares the pins against a cycle-exact expectation on every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Widest level index supported by the pick structure.
    localparam int LVL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // bus free or foreign owner, waiting
        ST_GRANT = 2'd1,   // grant driven, waiting for busy to be taken
        ST_OWNED = 2'd2    // grant withdrawn, owner holds busy
    } arb_state_e;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } arb_pick_t;

    function automatic logic level_above(input logic [LVL_W-1:0] a,
                                         input logic [LVL_W-1:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic        IDLE_V  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= {W{IDLE_V}};
                else if (s == 0)
                    stage_q[s] <= d_async;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/arb_prio.sv
module arb_prio
    import arb_pkg::*;
#(
    parameter int LEVELS = 4
) (
    input  logic [LEVELS-1:0] req_act,
    input  logic [LVL_W-1:0]  own_lvl,
    output arb_pick_t         pick,
    output logic              above_owner
);
    always_comb begin
        pick = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (req_act[i]) begin
                pick.valid = 1'b1;
                pick.lvl   = LVL_W'(i);
            end
        end
    end

    always_comb begin
        above_owner = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (req_act[i] && level_above(LVL_W'(i), own_lvl))
                above_owner = 1'b1;
        end
    end
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
#(
    parameter int LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:0] req_act,
    input  logic              bus_busy,
    input  arb_pick_t         pick,
    input  logic              above_owner,
    output logic [LVL_W-1:0]  own_lvl,
    output logic [LEVELS-1:0] gnt,
    output logic              clr
);
    arb_state_e st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            gnt     <= '0;
            clr     <= 1'b0;
            own_lvl <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!bus_busy && pick.valid) begin
                        gnt          <= '0;
                        gnt[pick.lvl] <= 1'b1;
                        own_lvl      <= pick.lvl;
                        st_q         <= ST_GRANT;
                    end
                end
                ST_GRANT: begin
                    if (bus_busy) begin
                        gnt  <= '0;
                        st_q <= ST_OWNED;
                    end
                end
                ST_OWNED: begin
                    if (!bus_busy) begin
                        clr  <= 1'b0;
                        st_q <= ST_IDLE;
                    end else if (above_owner) begin
                        clr <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (gnt == '0 && !clr));

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r3_grant_on_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> !$past(bus_busy));

    a_r4_no_higher_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gnt) |-> (($past(req_act) & ~((gnt << 1) - 1'b1)) == '0));

    a_r5_grant_released: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt && bus_busy) |=> !(|gnt));

    a_r6_clear_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr) |-> $past(bus_busy) && !(|gnt));

    a_r7_clear_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !bus_busy) |=> !clr);
endmodule

// File: rtl/bkp_arbiter.sv
module bkp_arbiter
    import arb_pkg::*;
#(
    parameter int LEVELS      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic [LEVELS-1:0] req_n,
    input  logic              busy_n,
    output logic [LEVELS-1:0] grant_n,
    output logic              clr_n
);
    localparam int IN_W = LEVELS + 1;

    logic [IN_W-1:0]   in_sync;
    logic [LEVELS-1:0] req_act;
    logic              bus_busy;
    arb_pick_t         pick;
    logic              above_owner;
    logic [LVL_W-1:0]  own_lvl;
    logic [LEVELS-1:0] gnt;
    logic              clr;

    initial begin
        if (LEVELS > (1 << LVL_W)) $error("LEVELS exceeds pick width");
    end

    // R8: every backplane line retimed before use
    arb_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .IDLE_V(1'b1)) u_sync (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .d_async({busy_n, req_n}),
        .d_sync (in_sync)
    );

    assign req_act  = ~in_sync[LEVELS-1:0];
    assign bus_busy = ~in_sync[LEVELS];

    arb_prio #(.LEVELS(LEVELS)) u_prio (
        .req_act    (req_act),
        .own_lvl    (own_lvl),
        .pick       (pick),
        .above_owner(above_owner)
    );

    arb_fsm #(.LEVELS(LEVELS)) u_fsm (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .req_act    (req_act),
        .bus_busy   (bus_busy),
        .pick       (pick),
        .above_owner(above_owner),
        .own_lvl    (own_lvl),
        .gnt        (gnt),
        .clr        (clr)
    );

    assign grant_n = ~gnt;
    assign clr_n   = ~clr;
endmodule

// File: tb/test_bkp_arbiter.sv
module test_bkp_arbiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       busy_n = 1'b1;
    logic [3:0] grant_n;
    logic       clr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkp_arbiter i_bkp_arbiter (
        .clk(clk), .sys_rst_n(sys_rst_n), .req_n(req_n),
        .busy_n(busy_n), .grant_n(grant_n), .clr_n(clr_n)
    );

    // Expected-behaviour model built from the requirements.
    logic [3:0] m_r1, m_r2;
    logic       m_b1, m_b2;
    int         m_st;   // 0 idle, 1 granted, 2 owned
    int         m_lvl;
    logic [3:0] m_gnt;
    logic       m_clr;

    function automatic int top_level(input logic [3:0] act);
        int t = -1;
        for (int i = 0; i < 4; i++) if (act[i]) t = i;
        return t;
    endfunction

    function automatic bit any_above(input logic [3:0] act, input int lvl);
        for (int i = 0; i < 4; i++) if (act[i] && i > lvl) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!sys_rst_n) begin
            m_r1 <= 4'hF; m_r2 <= 4'hF; m_b1 <= 1'b1; m_b2 <= 1'b1;
            m_st <= 0; m_lvl <= 0; m_gnt <= 4'h0; m_clr <= 1'b0;
        end else begin
            m_r1 <= req_n; m_r2 <= m_r1; m_b1 <= busy_n; m_b2 <= m_b1;
            case (m_st)
                0: if (m_b2 && m_r2 != 4'hF) begin
                       m_lvl <= top_level(~m_r2);
                       m_gnt <= 4'h1 << top_level(~m_r2);
                       m_st  <= 1;
                   end
                1: if (!m_b2) begin m_gnt <= 4'h0; m_st <= 2; end
                default: if (m_b2) begin m_clr <= 1'b0; m_st <= 0; end
                         else if (any_above(~m_r2, m_lvl)) m_clr <= 1'b1;
            endcase
        end
    end

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {grant_n,clr_n} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the model; the tag reflects what changed.
    task automatic compare_model();
        string tag;
        logic [4:0] exp_v = {~m_gnt, ~m_clr};
        if (!sys_rst_n)               tag = "R1";
        else if (m_clr)               tag = "R6";
        else if (m_st == 0)           tag = "R7";
        else if (m_gnt != 0)          tag = "R4";
        else                          tag = "R5";
        check(tag, {grant_n, clr_n}, exp_v);
        if (!$onehot0(~grant_n)) check("R2", {grant_n, clr_n}, {4'hF, clr_n});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] want;
        int owner, phase, cnt;
        void'($urandom(32'd20240517));

        // R1: reset state
        repeat (3) step();
        check("R1", {grant_n, clr_n}, 5'b11111);
        @(negedge clk) sys_rst_n = 1'b1;
        step();

        // R8: request latency through the synchronizer
        @(negedge clk) req_n = 4'b1101;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R8", {grant_n, clr_n}, 5'b11111);
        @(posedge clk); @(negedge clk);
        check("R8", {grant_n, clr_n}, 5'b11011);

        // R5: grant withdrawn three edges after busy falls
        busy_n = 1'b0; req_n = 4'hF;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5", {grant_n, clr_n}, 5'b11011);
        @(posedge clk); @(negedge clk);
        check("R5", {grant_n, clr_n}, 5'b11111);

        // R6: higher request raises clear, lower does not
        req_n = 4'b1110;
        repeat (4) step();
        check("R6", {grant_n, clr_n}, 5'b11111);
        req_n = 4'b0110;
        repeat (4) step();
        check("R6", {grant_n, clr_n}, 5'b11110);

        // R3: requests ignored while busy held; R7 and R4 after release
        repeat (10) begin
            step();
            check("R3", {grant_n[3], grant_n[2], grant_n[1], grant_n[0]} == 4'hF ? 5'b0 : 5'b1, 5'b0);
        end
        busy_n = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        check("R7", {grant_n, clr_n}, 5'b11111);
        @(posedge clk); @(negedge clk);
        check("R4", {grant_n, clr_n}, 5'b01111);
        busy_n = 1'b0; req_n = 4'b1110;
        repeat (4) step();
        busy_n = 1'b1;
        repeat (4) step();
        check("R4", {grant_n, clr_n}, 5'b11101);
        busy_n = 1'b0; req_n = 4'hF;
        repeat (4) step();
        busy_n = 1'b1;
        repeat (4) step();

        // Random cards on the backplane
        want = 4'h0; owner = -1; phase = 0; cnt = 0;
        repeat (6000) begin
            step();
            if ($urandom % 400 == 0) begin
                sys_rst_n = 1'b0; busy_n = 1'b1; want = 4'h0; phase = 0;
            end else begin
                sys_rst_n = 1'b1;
                case (phase)
                    0: if (grant_n != 4'hF) begin
                           owner = top_level(~grant_n);
                           phase = 1; cnt = $urandom % 3;
                       end
                    1: if (cnt == 0) begin
                           busy_n = 1'b0; want[owner] = 1'b0;
                           phase = 2; cnt = 2 + $urandom % 15;
                       end else cnt--;
                    default: begin
                        if (!clr_n && cnt > 3) cnt = 3;
                        if (cnt == 0) begin busy_n = 1'b1; phase = 0; end
                        else cnt--;
                    end
                endcase
                if ($urandom % 4 == 0) want[$urandom % 4] = 1'b1;
            end
            req_n = ~want;
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule